// File: doc/BRIEF.md
# General-purpose I/O port with per-pin interrupt triggers

This block is a 32-pin general-purpose I/O port with a simple word-addressed register bus. Software writes an output value register and a direction register, and the port drives the pins from these. The actual pad levels come back through a read-only status register. Each pad input passes through a two-flop synchronizer before any logic sees it.

Each pin has a 2-bit trigger field. The field selects one of four conditions: a low level, a high level, a rising edge or a falling edge. The port has no mode that triggers on both edges. A triggered pin sets a sticky pending bit, which software clears by writing 1 to that bit. An enable register lets each pin take part in the interrupt outputs. Two combined interrupt lines come out: one covers pins 0 to 15, the other covers pins 16 to 31.

The register map uses word addresses:

| Address | Register |
|---|---|
| 0 | Output value |
| 1 | Direction |
| 2 | Pad status (read-only) |
| 3 | Trigger fields, lower half |
| 4 | Trigger fields, upper half |
| 5 | Interrupt enable |
| 6 | Pending |
| 7 | Unused, reads zero |

Top module: `gpio32_port`

## Requirements
- R1: While reset is asserted, and until the first write, the port is in its reset state. Every pin is an input (`pin_oe` = 0) and `pin_out` is 0. The enable and pending registers read 0, and both interrupt lines are low.
- R2: A write to address 0 appears on `pin_out` after the capturing edge. A write to address 1 appears on `pin_oe` after the capturing edge, where 1 means the pin is driven. Both registers read back what was written. Address 7 reads zero.
- R3: Address 2 returns the pad levels on `pin_in` whatever the direction. A pin change becomes visible after the second rising clock edge that follows it. Writes to address 2 have no effect.
- R4: Pin n has its trigger field at bits 2n+1:2n of address 3 for n < 16, and at bits 2(n-16)+1:2(n-16) of address 4 for n >= 16. The encoding is 00 for low level, 01 for high level, 10 for rising edge and 11 for falling edge. Both trigger registers read back what was written.
- R5: A pin in rising mode sets its pending bit on the third rising edge after a 0-to-1 change of `pin_in`. A pin in falling mode does the same for a 1-to-0 change. A transition in the other direction sets nothing.
- R6: A pin in a level mode sets its pending bit on every cycle while the selected level is present. After reset all fields are 00, so every pin that is low becomes pending.
- R7: Writing 1 to a bit of address 6 clears that pending bit, and writing 0 leaves it unchanged. An edge event that falls in the same cycle as the clearing write wins, and the bit stays set. A level condition does not win: the bit reads 0 for one cycle and then sets again.
- R8: A write to address 3 or 4 clears the pending bit of every pin whose trigger field value changes. Pins whose fields are written with the same value keep their pending state.
- R9: Address 5 holds one enable bit per pin, where 1 means the pin takes part. `irq_lo` is the OR of the pending and enabled pins 0 to 15. `irq_hi` is the same OR for pins 16 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad output enables, 1 = driven |
| irq_lo | output | 1 | Combined interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Combined interrupt for pins 16 to 31 |

## Verification
A software write that clears a pending bit can land on the same clock edge as a new trigger event for that pin. The bench provokes this with precise timing: it changes a pin in rising mode and places the clearing write on the third edge after the change. It expects the bit, and the combined interrupt, to stay set. It then repeats the collision for a pin in high-level mode, where the bit must read 0 for exactly one cycle before it sets again. Random pin, trigger, enable and clear traffic is checked against a bench model of the pending register after each step.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_RISE = 2'b10,
    TRG_FALL = 2'b11
  } trig_mode_e;

  localparam logic [ADDR_W-1:0] A_DOUT    = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR     = 3'd1;
  localparam logic [ADDR_W-1:0] A_PAD     = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIG_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN     = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEND    = 3'd6;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [W-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = din;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign cur  = s2_q;
  assign prev = s3_q;

endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_pkg::*;
(
  input  trig_mode_e mode,
  input  logic       cur,
  input  logic       prev,
  output logic       edge_hit,
  output logic       level_hit
);

  always_comb begin
    edge_hit  = 1'b0;
    level_hit = 1'b0;
    unique case (mode)
      TRG_LOW:  level_hit = !cur;
      TRG_HIGH: level_hit = cur;
      TRG_RISE: edge_hit  = cur && !prev;
      TRG_FALL: edge_hit  = !cur && prev;
      default:  ;
    endcase
  end

endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
  parameter int NPIN = 32,
  localparam int HALF = NPIN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] edge_hit,
  input  logic [NPIN-1:0] level_hit,
  input  logic [NPIN-1:0] clr,
  input  logic [NPIN-1:0] kill,
  input  logic [NPIN-1:0] ien,
  output logic [NPIN-1:0] pend,
  output logic            irq_lo,
  output logic            irq_hi
);

  logic [NPIN-1:0] pend_q, pend_d, set_v, keep_v;

  always_comb begin
    // edge events beat a clearing write; level conditions yield for one cycle
    set_v  = (edge_hit | (level_hit & ~clr)) & ~kill;
    keep_v = pend_q & ~clr & ~kill;
    pend_d = keep_v | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend   = pend_q;
  assign irq_lo = |(pend_q[HALF-1:0]    & ien[HALF-1:0]);
  assign irq_hi = |(pend_q[NPIN-1:HALF] & ien[NPIN-1:HALF]);

endmodule

// File: rtl/gpio32_port.sv
module gpio32_port
  import gpio_pkg::*;
#(
  parameter int NPIN = 32,
  localparam int HALF = NPIN / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq_lo,
  output logic              irq_hi
);

  logic rst_sync_n;

  gpio_rst_sync i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // register file
  logic [NPIN-1:0] dout_q, dir_q, trig_lo_q, trig_hi_q, ien_q;
  logic [NPIN-1:0] dout_d, dir_d, trig_lo_d, trig_hi_d, ien_d;
  logic wr_dout, wr_dir, wr_trig_lo, wr_trig_hi, wr_ien, wr_pend;

  always_comb begin
    wr_dout    = bus_we && (bus_addr == A_DOUT);
    wr_dir     = bus_we && (bus_addr == A_DIR);
    wr_trig_lo = bus_we && (bus_addr == A_TRIG_LO);
    wr_trig_hi = bus_we && (bus_addr == A_TRIG_HI);
    wr_ien     = bus_we && (bus_addr == A_IEN);
    wr_pend    = bus_we && (bus_addr == A_PEND);
  end

  always_comb begin
    dout_d    = wr_dout    ? bus_wdata : dout_q;
    dir_d     = wr_dir     ? bus_wdata : dir_q;
    trig_lo_d = wr_trig_lo ? bus_wdata : trig_lo_q;
    trig_hi_d = wr_trig_hi ? bus_wdata : trig_hi_q;
    ien_d     = wr_ien     ? bus_wdata : ien_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q    <= '0;
      dir_q     <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      ien_q     <= '0;
    end else begin
      dout_q    <= dout_d;
      dir_q     <= dir_d;
      trig_lo_q <= trig_lo_d;
      trig_hi_q <= trig_hi_d;
      ien_q     <= ien_d;
    end
  end

  // pad input path
  logic [NPIN-1:0] pin_cur, pin_prev;

  gpio_sync #(.W(NPIN)) i_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (pin_in),
    .cur  (pin_cur),
    .prev (pin_prev)
  );

  // per-pin trigger decode and reconfiguration kill
  logic [NPIN-1:0] edge_hit, level_hit, kill, clr, any_hit, pend;

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic [1:0] fld_now;
    logic [1:0] fld_new;
    logic       fld_wr;
    if (n < HALF) begin : g_lo
      assign fld_now = trig_lo_q[2*n +: 2];
      assign fld_wr  = wr_trig_lo;
    end else begin : g_hi
      assign fld_now = trig_hi_q[2*(n-HALF) +: 2];
      assign fld_wr  = wr_trig_hi;
    end
    assign fld_new = bus_wdata[2*(n%HALF) +: 2];
    assign kill[n] = fld_wr && (fld_new != fld_now);

    gpio_pin_event i_evt (
      .mode     (trig_mode_e'(fld_now)),
      .cur      (pin_cur[n]),
      .prev     (pin_prev[n]),
      .edge_hit (edge_hit[n]),
      .level_hit(level_hit[n])
    );
  end

  assign clr     = wr_pend ? bus_wdata : '0;
  assign any_hit = edge_hit | level_hit;

  gpio_pend #(.NPIN(NPIN)) i_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .edge_hit (edge_hit),
    .level_hit(level_hit),
    .clr      (clr),
    .kill     (kill),
    .ien      (ien_q),
    .pend     (pend),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi)
  );

  // read path
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DOUT:    bus_rdata = dout_q;
      A_DIR:     bus_rdata = dir_q;
      A_PAD:     bus_rdata = pin_cur;
      A_TRIG_LO: bus_rdata = trig_lo_q;
      A_TRIG_HI: bus_rdata = trig_hi_q;
      A_IEN:     bus_rdata = ien_q;
      A_PEND:    bus_rdata = pend;
      default:   bus_rdata = '0;
    endcase
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio32_port_chk.sv
module gpio32_port_chk #(
  parameter int NPIN = 32,
  localparam int HALF = NPIN / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] ien,
  input logic [NPIN-1:0] pend,
  input logic [NPIN-1:0] any_hit,
  input logic [1:0]      trig_fld0,
  input logic            irq_lo,
  input logic            irq_hi
);

  // R2
  dout_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0) |=> (pin_out == $past(bus_wdata)));

  // R2
  dir_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1) |=> (pin_oe == $past(bus_wdata)));

  // R9
  lo_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[HALF-1:0] == '0) |-> !irq_lo);

  // R9
  hi_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[NPIN-1:HALF] == '0) |-> !irq_hi);

  // R5
  pend_rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(any_hit)) == '0));

  // R8
  reconfig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3 && bus_wdata[1:0] != trig_fld0) |=> !pend[0]);

endmodule

bind gpio32_port gpio32_port_chk #(.NPIN(NPIN)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .ien      (ien_q),
  .pend     (pend),
  .any_hit  (any_hit),
  .trig_fld0(trig_lo_q[1:0]),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi)
);

// File: tb/test_gpio32_port.sv
`timescale 1ns/1ps
module test_gpio32_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out, pin_oe;
  logic        irq_lo, irq_hi;

  always #2.5 clk = ~clk;

  gpio32_port i_gpio32_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_lo, m_hi, m_ien, m_pend, m_dout, m_dir;

  function automatic logic [1:0] mode_of(int n);
    if (n < 16) return m_lo[2*n +: 2];
    return m_hi[2*(n-16) +: 2];
  endfunction

  function automatic logic [31:0] level_hits(logic [31:0] lv);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      if (mode_of(n) == 2'b00 && !lv[n]) r[n] = 1'b1;
      if (mode_of(n) == 2'b01 &&  lv[n]) r[n] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] edge_hits(logic [31:0] o, logic [31:0] v);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) begin
      if (mode_of(n) == 2'b10 && !o[n] &&  v[n]) r[n] = 1'b1;
      if (mode_of(n) == 2'b11 &&  o[n] && !v[n]) r[n] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check_irq(string req);
    logic [31:0] v;
    rd(3'd6, v);
    check(req, v, m_pend);
    check(req, {31'd0, irq_lo}, {31'd0, |(m_pend[15:0] & m_ien[15:0])});
    check(req, {31'd0, irq_hi}, {31'd0, |(m_pend[31:16] & m_ien[31:16])});
  endtask

  task automatic set_pins(logic [31:0] v);
    logic [31:0] o = pin_in;
    @(negedge clk);
    pin_in = v;
    idle(4);
    m_pend = m_pend | edge_hits(o, v) | level_hits(v);
  endtask

  task automatic trig_write(bit hi, logic [31:0] d);
    logic [31:0] chg = '0;
    for (int n = 0; n < 16; n++)
      if ((hi ? m_hi[2*n +: 2] : m_lo[2*n +: 2]) != d[2*n +: 2])
        chg[hi ? n + 16 : n] = 1'b1;
    wr(hi ? 3'd4 : 3'd3, d);
    if (hi) m_hi = d; else m_lo = d;
    m_pend = (m_pend & ~chg) | level_hits(pin_in);
    idle(2);
  endtask

  task automatic w1c(logic [31:0] d);
    wr(3'd6, d);
    idle(2);
    m_pend = (m_pend & ~d) | level_hits(pin_in);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1d0c_5eed));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    m_lo = '0; m_hi = '0; m_ien = '0; m_pend = '0; m_dout = '0; m_dir = '0;
    idle(3);
    // R1 reset state
    check("R1 oe", pin_oe, '0);
    check("R1 out", pin_out, '0);
    check("R1 irq", {30'd0, irq_hi, irq_lo}, '0);
    rd(3'd6, v); check("R1 pend", v, '0);
    rd(3'd5, v); check("R1 ien", v, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(6);
    // R6 all fields low-level after reset, pins low -> all pending
    m_pend = 32'hffff_ffff;
    check_irq("R6 reset-level");

    // R8 move everything to rising: all fields change -> all cleared
    trig_write(0, 32'haaaa_aaaa);
    trig_write(1, 32'haaaa_aaaa);
    check_irq("R8 reconfig");
    rd(3'd4, v); check("R4 readback", v, 32'haaaa_aaaa);
    wr(3'd5, 32'hffff_ffff); m_ien = 32'hffff_ffff;

    // R3/R5 latency of pin 5 rising
    @(negedge clk); pin_in[5] = 1'b1;
    @(posedge clk); rd(3'd2, v); check("R3 pad after 1 edge", v[5], 1'b0);
    check("R5 early irq", irq_lo, 1'b0);
    @(posedge clk); #1 v = bus_rdata; check("R3 pad after 2 edges", v[5], 1'b1);
    check("R5 irq before 3rd edge", irq_lo, 1'b0);
    @(posedge clk); @(negedge clk); check("R5 irq at 3rd edge", irq_lo, 1'b1);
    m_pend[5] = 1'b1;
    w1c(32'h0000_0020);
    check_irq("R7 clear edge pin");
    set_pins(pin_in & ~32'h20);
    check_irq("R5 falling ignored in rise mode");

    // R7 collision on pin 20, rising mode
    set_pins(pin_in | 32'h0010_0000);
    check_irq("R5 pin20 rise");
    set_pins(pin_in & ~32'h0010_0000);
    @(negedge clk); pin_in[20] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_addr = 3'd6; bus_we = 1'b1; bus_wdata = 32'h0010_0000;
    @(posedge clk); @(negedge clk); bus_we = 1'b0;
    #1 check("R7 edge wins over clear", bus_rdata[20], 1'b1);
    check("R7 irq_hi kept", irq_hi, 1'b1);
    idle(2);
    check_irq("R7 after collision");

    // R6 level high on pin 2, clear then re-set
    trig_write(0, 32'haaaa_aa9a);
    set_pins(pin_in | 32'h4);
    check_irq("R6 high level");
    @(negedge clk); bus_addr = 3'd6; bus_we = 1'b1; bus_wdata = 32'h4;
    @(negedge clk); bus_we = 1'b0;
    #1 check("R6 cleared one cycle", bus_rdata[2], 1'b0);
    @(negedge clk); #1 check("R6 set again", bus_rdata[2], 1'b1);
    trig_write(0, 32'haaaa_aa9a);
    check_irq("R8 same value keeps");
    trig_write(0, 32'haaaa_aa8a);
    check_irq("R8 changed field clears");

    // R4 falling on pin 31 at top bits of upper register
    trig_write(1, 32'heaaa_aaaa);
    set_pins(pin_in | 32'h8000_0000);
    check_irq("R4 fall no set on rise");
    set_pins(pin_in & ~32'h8000_0000);
    check_irq("R4 fall sets");

    // R2 outputs and map
    wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h0f0f_00ff);
    @(negedge clk);
    check("R2 out", pin_out, 32'h1234_5678);
    check("R2 oe", pin_oe, 32'h0f0f_00ff);
    rd(3'd1, v); check("R2 dir rb", v, 32'h0f0f_00ff);
    rd(3'd7, v); check("R2 addr7", v, '0);
    wr(3'd2, ~pin_in); rd(3'd2, v); check("R3 pad write ignored", v, pin_in);

    // random traffic
    for (int it = 0; it < 120; it++) begin
      int op = $urandom % 5;
      logic [31:0] r = $urandom;
      case (op)
        0: set_pins(pin_in ^ (r & $urandom));
        1: trig_write(r[0], $urandom);
        2: begin wr(3'd5, r); m_ien = r; idle(1); end
        3: w1c(r);
        default: begin
          wr(3'd0, r); @(negedge clk);
          check("R2 rand out", pin_out, r);
          rd(3'd2, v); check("R3 rand pad", v, pin_in);
        end
      endcase
      check_irq(op == 2 ? "R9 rand" : op == 3 ? "R7 rand" : op == 1 ? "R8 rand" : "R5 rand");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule